// File: doc/BRIEF.md
# Intra 4x4 Luma Predictor

This block forms the sixteen predicted samples of a single 4x4 luma block from the already reconstructed samples around it. A request carries the prediction mode, which may be any of the eight directional modes or DC. It also carries four availability flags, for the left, top, top-right and top-left neighbours, and the horizontal block position within the picture row. The block then emits one predicted sample per cycle in raster order, and each sample comes with an enable pulse that a downstream adder uses to push the sum into its output FIFO.

The neighbour samples are not supplied with the request. The predictor keeps them itself. A left-column buffer holds the right edge of the previous block. A line buffer, one picture row of block bottoms wide, holds the bottom edges of the row above. A corner register keeps the top-left sample. The reconstructed samples of each block are written back through a separate port, and that write-back refreshes all three stores. Blocks are handled strictly one at a time, and the write-back for a block comes after its prediction burst.

Top module: `intra4_luma_pred`

## Requirements
- R1: While reset is asserted and right after it, `predValid` and `busy` are low.
- R2: A `start` seen while `busy` is low raises `busy` on the next cycle. From the cycle after that, `predValid` is high for exactly 16 consecutive cycles with `predIdx` counting 0 to 15, where index = 4*row + column. `busy` is low again in the cycle that shows index 15, and `predValid` drops after index 15.
- R3: A `start` seen while `busy` is high is ignored. The running burst keeps its mode and samples, and no extra burst follows it.
- R4: Mode 0 (vertical) copies the top sample of each column. Mode 1 (horizontal) copies the left sample of each row.
- R5: Mode 2 (DC) outputs the rounded mean of the available top and left samples: all eight samples when both sides are available, otherwise the four samples of the one available side. It outputs 128 when neither side is available.
- R6: Mode 3 (down-left diagonal) and mode 4 (down-right diagonal) use the 3-tap filter (a+2b+c+2)>>2 along their diagonal.
- R7: Modes 5 (vertical-right), 6 (horizontal-down), 7 (vertical-left) and 8 (horizontal-up) mix the 2-tap filter (a+b+1)>>1 and the 3-tap filter according to the position of the sample.
- R8: An unavailable left, top or top-left sample reads as 128 in the directional modes. When top-right is unavailable, or the block is the last one in the row, the fourth top sample is repeated in place of the four top-right samples.
- R9: Written-back samples with index 3, 7, 11 and 15 become the left neighbours of the next block.
- R10: Written-back samples with index 12 to 15 are stored at the current block position of the line buffer. They serve as top neighbours for the block below and as top-right neighbours for the block below-left.
- R11: The top-left neighbour of a block is the bottom-right sample of the block above-left. It stays correct even though the line-buffer slot that held it has already been rewritten in the current row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to predict one block |
| mode | input | 4 | Prediction mode 0..8 |
| availLeft | input | 1 | Left neighbour samples are usable |
| availTop | input | 1 | Top neighbour samples are usable |
| availTopRight | input | 1 | Top-right neighbour samples are usable |
| availTopLeft | input | 1 | Top-left corner sample is usable |
| blkX | input | BX_W | Block column in the picture row |
| reconValid | input | 1 | Write-back sample strobe |
| reconIdx | input | 4 | Raster index of the written-back sample |
| reconPix | input | PIX_W | Reconstructed sample value |
| busy | output | 1 | A burst is in progress |
| predValid | output | 1 | Enable toward the summation stage |
| predIdx | output | 4 | Raster index of the predicted sample |
| predPix | output | PIX_W | Predicted sample |

## Verification
The hardest case to reach from the ports is the top-left corner after its line-buffer slot has been rewritten by the left neighbour. That case, together with top-right reuse across rows, only shows up after several full rows of predict-then-write-back traffic. The bench therefore walks a 4x4-block picture in raster order. It writes back a known synthetic picture after every block and predicts each block from that picture with a model that is independent of the buffers, so any stale edge, corner or top-right sample shows up as a wrong predicted value. A start pulse injected halfway through a burst, with a different mode, covers the ignored-request case.

// File: rtl/intra4_pkg.sv
package intra4_pkg;

  typedef enum logic [3:0] {
    MODE_VERT = 4'd0,
    MODE_HORZ = 4'd1,
    MODE_DC   = 4'd2,
    MODE_DDL  = 4'd3,
    MODE_DDR  = 4'd4,
    MODE_VR   = 4'd5,
    MODE_HD   = 4'd6,
    MODE_VL   = 4'd7,
    MODE_HU   = 4'd8
  } predMode_e;

  typedef struct packed {
    logic       latchCfg;
    logic       emitPix;
    logic [3:0] pixIdx;
  } ctrlStrobe_t;

  localparam int BLK_PIX = 16;

endpackage

// File: rtl/intra4_ctrl.sv
module intra4_ctrl
  import intra4_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output ctrlStrobe_t strb
);

  localparam logic [3:0] LAST_IDX = 4'(BLK_PIX - 1);

  logic       running;
  logic [3:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end else begin
      cnt <= cnt + 4'd1;
      if (cnt == LAST_IDX) running <= 1'b0;
    end
  end

  always_comb begin
    strb.latchCfg = start && !running;
    strb.emitPix  = running;
    strb.pixIdx   = cnt;
  end

  assign busy = running;

endmodule

// File: rtl/intra4_dp.sv
module intra4_dp
  import intra4_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int ROW_BLKS = 4,
  parameter int BX_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [3:0]       mode,
  input  logic [3:0]       avail,
  input  logic [BX_W-1:0]  blkX,
  input  logic             reconValid,
  input  logic [3:0]       reconIdx,
  input  logic [PIX_W-1:0] reconPix,
  output logic             predValid,
  output logic [3:0]       predIdx,
  output logic [PIX_W-1:0] predPix
);

  localparam int              LINE_PIX = ROW_BLKS * 4;
  localparam int              IDX_W    = BX_W + 2;
  localparam int              NB_CNT   = 13;
  localparam logic [PIX_W-1:0] MID     = PIX_W'(1 << (PIX_W - 1));
  localparam logic [BX_W-1:0] LAST_BX  = BX_W'(ROW_BLKS - 1);

  logic [3:0]       cfgMode;
  logic [3:0]       cfgAvail;   // {topLeft, topRight, top, left}
  logic [BX_W-1:0]  cfgBlkX;
  logic [PIX_W-1:0] lineBuf [LINE_PIX];
  logic [PIX_W-1:0] leftBuf [4];
  logic [PIX_W-1:0] cornerPix;
  logic [PIX_W-1:0] nb [NB_CNT];  // L3 L2 L1 L0 M A B C D E F G H
  logic [PIX_W-1:0] dcVal;
  logic [PIX_W-1:0] pix;

  function automatic logic [PIX_W-1:0] f3(input logic [PIX_W-1:0] a, b, c);
    logic [PIX_W+1:0] s;
    s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c} + (PIX_W+2)'(2);
    return s[PIX_W+1:2];
  endfunction

  function automatic logic [PIX_W-1:0] f2(input logic [PIX_W-1:0] a, b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    return s[PIX_W:1];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode  <= '0;
      cfgAvail <= '0;
      cfgBlkX  <= '0;
    end else if (strb.latchCfg) begin
      cfgMode  <= mode;
      cfgAvail <= avail;
      cfgBlkX  <= blkX;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINE_PIX; i++) lineBuf[i] <= '0;
      for (int i = 0; i < 4; i++) leftBuf[i] <= '0;
      cornerPix <= '0;
    end else if (reconValid) begin
      if (reconIdx[1:0] == 2'd3) leftBuf[reconIdx[3:2]] <= reconPix;
      if (reconIdx[3:2] == 2'd3) lineBuf[{cfgBlkX, reconIdx[1:0]}] <= reconPix;
      if (reconIdx == 4'd15) cornerPix <= lineBuf[{cfgBlkX, 2'd3}];
    end
  end

  // Neighbour gather with substitution for unusable samples.
  always_comb begin
    logic [IDX_W-1:0] trBase;
    trBase = {cfgBlkX + BX_W'(1), 2'd0};
    for (int k = 0; k < 4; k++) begin
      nb[3-k] = cfgAvail[0] ? leftBuf[k] : MID;
      nb[5+k] = cfgAvail[1] ? lineBuf[{cfgBlkX, 2'(k)}] : MID;
    end
    nb[4] = cfgAvail[3] ? cornerPix : MID;
    for (int k = 0; k < 4; k++) begin
      nb[9+k] = (cfgAvail[2] && cfgBlkX != LAST_BX) ? lineBuf[trBase + IDX_W'(k)] : nb[8];
    end
  end

  always_comb begin
    logic [PIX_W+1:0] sumT, sumL;
    logic [PIX_W+2:0] dcSum;
    sumT = '0;
    sumL = '0;
    for (int k = 0; k < 4; k++) begin
      sumT = sumT + (PIX_W+2)'(nb[5+k]);
      sumL = sumL + (PIX_W+2)'(nb[3-k]);
    end
    dcSum = '0;
    dcVal = MID;
    if (cfgAvail[0] && cfgAvail[1]) begin
      dcSum = {1'b0, sumT} + {1'b0, sumL} + (PIX_W+3)'(4);
      dcVal = dcSum[PIX_W+2:3];
    end else if (cfgAvail[1]) begin
      dcSum = {1'b0, sumT} + (PIX_W+3)'(2);
      dcVal = dcSum[PIX_W+1:2];
    end else if (cfgAvail[0]) begin
      dcSum = {1'b0, sumL} + (PIX_W+3)'(2);
      dcVal = dcSum[PIX_W+1:2];
    end
  end

  // Per-sample selection; x = column, y = row of the current index.
  always_comb begin
    int x, y, z, k, j0, j1, j2;
    x  = int'(strb.pixIdx[1:0]);
    y  = int'(strb.pixIdx[3:2]);
    z  = 0;
    k  = 0;
    j0 = 0; j1 = 0; j2 = 0;
    pix = MID;
    case (cfgMode)
      MODE_VERT: pix = nb[5+x];
      MODE_HORZ: pix = nb[3-y];
      MODE_DC:   pix = dcVal;
      MODE_DDL: begin
        if (x == 3 && y == 3) pix = f3(nb[11], nb[12], nb[12]);
        else                  pix = f3(nb[5+x+y], nb[6+x+y], nb[7+x+y]);
      end
      MODE_DDR: pix = f3(nb[3+x-y], nb[4+x-y], nb[5+x-y]);
      MODE_VR: begin
        z = 2*x - y;
        k = x - (y >> 1);
        if (z >= 0 && z[0] == 1'b0) pix = f2(nb[4+k], nb[5+k]);
        else if (z > 0)             pix = f3(nb[3+k], nb[4+k], nb[5+k]);
        else if (z == -1)           pix = f3(nb[3], nb[4], nb[5]);
        else                        pix = f3(nb[4-y], nb[5-y], nb[6-y]);
      end
      MODE_HD: begin
        z = 2*y - x;
        k = y - (x >> 1);
        if (z >= 0 && z[0] == 1'b0) pix = f2(nb[4-k], nb[3-k]);
        else if (z > 0)             pix = f3(nb[5-k], nb[4-k], nb[3-k]);
        else if (z == -1)           pix = f3(nb[3], nb[4], nb[5]);
        else                        pix = f3(nb[4+x], nb[3+x], nb[2+x]);
      end
      MODE_VL: begin
        k = x + (y >> 1);
        if (y[0] == 1'b0) pix = f2(nb[5+k], nb[6+k]);
        else              pix = f3(nb[5+k], nb[6+k], nb[7+k]);
      end
      MODE_HU: begin
        z  = x + 2*y;
        k  = y + (x >> 1);
        j0 = (k     > 3) ? 3 : k;
        j1 = (k + 1 > 3) ? 3 : k + 1;
        j2 = (k + 2 > 3) ? 3 : k + 2;
        if (z[0] == 1'b0) pix = f2(nb[3-j0], nb[3-j1]);
        else              pix = f3(nb[3-j0], nb[3-j1], nb[3-j2]);
      end
      default: pix = MID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predIdx   <= '0;
      predPix   <= '0;
    end else begin
      predValid <= strb.emitPix;
      if (strb.emitPix) begin
        predIdx <= strb.pixIdx;
        predPix <= pix;
      end
    end
  end

endmodule

// File: rtl/intra4_luma_pred.sv
module intra4_luma_pred
  import intra4_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int ROW_BLKS = 4,
  localparam int BX_W    = $clog2(ROW_BLKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       mode,
  input  logic             availLeft,
  input  logic             availTop,
  input  logic             availTopRight,
  input  logic             availTopLeft,
  input  logic [BX_W-1:0]  blkX,
  input  logic             reconValid,
  input  logic [3:0]       reconIdx,
  input  logic [PIX_W-1:0] reconPix,
  output logic             busy,
  output logic             predValid,
  output logic [3:0]       predIdx,
  output logic [PIX_W-1:0] predPix
);

  ctrlStrobe_t strb;

  intra4_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .busy  (busy),
    .strb  (strb)
  );

  intra4_dp #(
    .PIX_W    (PIX_W),
    .ROW_BLKS (ROW_BLKS),
    .BX_W     (BX_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mode       (mode),
    .avail      ({availTopLeft, availTopRight, availTop, availLeft}),
    .blkX       (blkX),
    .reconValid (reconValid),
    .reconIdx   (reconIdx),
    .reconPix   (reconPix),
    .predValid  (predValid),
    .predIdx    (predIdx),
    .predPix    (predPix)
  );

endmodule

// File: rtl/intra4_luma_pred_chk.sv
module intra4_luma_pred_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       predValid,
  input logic [3:0] predIdx
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !predValid && !busy); // R1

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && !predValid); // R2

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(predValid) |-> predIdx == 4'd0); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    predValid && predIdx != 4'd15 |=> predValid && predIdx == $past(predIdx) + 4'd1); // R2

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rstN)
    predValid && predIdx == 4'd15 |=> !predValid); // R2

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    predValid && predIdx != 4'd15 |-> busy); // R2

endmodule

bind intra4_luma_pred intra4_luma_pred_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .predValid (predValid),
  .predIdx   (predIdx)
);

// File: tb/intra4_luma_pred_tb_top.sv
`timescale 1ns/1ps
module intra4_luma_pred_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] mode = '0;
  logic       availLeft = 1'b0, availTop = 1'b0, availTopRight = 1'b0, availTopLeft = 1'b0;
  logic [1:0] blkX = '0;
  logic       reconValid = 1'b0;
  logic [3:0] reconIdx = '0;
  logic [7:0] reconPix = '0;
  logic       busy, predValid;
  logic [3:0] predIdx;
  logic [7:0] predPix;

  int  checkCnt = 0;
  int  failCnt  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  intra4_luma_pred dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .availLeft(availLeft), .availTop(availTop),
    .availTopRight(availTopRight), .availTopLeft(availTopLeft),
    .blkX(blkX), .reconValid(reconValid), .reconIdx(reconIdx), .reconPix(reconPix),
    .busy(busy), .predValid(predValid), .predIdx(predIdx), .predPix(predPix)
  );

  // {mode, availability mask {topLeft, topRight, top, left}}, one per block, raster order.
  localparam logic [7:0] VEC [16] = '{
    8'h2F, 8'h1F, 8'h2F, 8'h8F,
    8'h0F, 8'h3F, 8'h4F, 8'h5F,
    8'h2F, 8'h6F, 8'h7F, 8'h3F,
    8'h4F, 8'h7B, 8'h2F, 8'h0F
  };

  function automatic int pic(int px, int py);
    return (px*29 + py*53 + px*py*7 + 11) & 255;
  endfunction

  function automatic int t3(int a, int b, int c);
    return (a + 2*b + c + 2) / 4;
  endfunction

  function automatic int t2(int a, int b);
    return (a + b + 1) / 2;
  endfunction

  // top[0] and lft[0] are the corner; top[k+1] = k-th top sample, lft[k+1] = k-th left sample.
  function automatic int refPix(int md, bit aL, bit aT, bit aTR, bit aTL, int bx, int by, int p);
    int top [9];
    int lft [5];
    int x, y, z, s;
    x = p % 4;
    y = p / 4;
    top[0] = aTL ? pic(bx*4-1, by*4-1) : 128;
    lft[0] = top[0];
    for (int k = 0; k < 4; k++) begin
      top[k+1] = aT ? pic(bx*4+k, by*4-1) : 128;
      lft[k+1] = aL ? pic(bx*4-1, by*4+k) : 128;
    end
    for (int k = 4; k < 8; k++) top[k+1] = aTR ? pic(bx*4+k, by*4-1) : top[4];
    case (md)
      0: return top[x+1];
      1: return lft[y+1];
      2: begin
        s = 0;
        if (aT && aL) begin
          for (int k = 1; k < 5; k++) s += top[k] + lft[k];
          return (s + 4) / 8;
        end else if (aT) begin
          for (int k = 1; k < 5; k++) s += top[k];
          return (s + 2) / 4;
        end else if (aL) begin
          for (int k = 1; k < 5; k++) s += lft[k];
          return (s + 2) / 4;
        end
        return 128;
      end
      3: begin
        if (x == 3 && y == 3) return t3(top[7], top[8], top[8]);
        return t3(top[x+y+1], top[x+y+2], top[x+y+3]);
      end
      4: begin
        if (x > y) return t3(top[x-y-1], top[x-y], top[x-y+1]);
        if (x < y) return t3(lft[y-x-1], lft[y-x], lft[y-x+1]);
        return t3(top[1], top[0], lft[1]);
      end
      5: begin
        z = 2*x - y;
        if (z >= 0 && z % 2 == 0) return t2(top[x-y/2], top[x-y/2+1]);
        if (z > 0) return t3(top[x-y/2-1], top[x-y/2], top[x-y/2+1]);
        if (z == -1) return t3(lft[1], lft[0], top[1]);
        return t3(lft[y], lft[y-1], lft[y-2]);
      end
      6: begin
        z = 2*y - x;
        if (z >= 0 && z % 2 == 0) return t2(lft[y-x/2], lft[y-x/2+1]);
        if (z > 0) return t3(lft[y-x/2-1], lft[y-x/2], lft[y-x/2+1]);
        if (z == -1) return t3(lft[1], lft[0], top[1]);
        return t3(top[x], top[x-1], top[x-2]);
      end
      7: begin
        if (y % 2 == 0) return t2(top[x+y/2+1], top[x+y/2+2]);
        return t3(top[x+y/2+1], top[x+y/2+2], top[x+y/2+3]);
      end
      default: begin
        z = x + 2*y;
        if (z > 5) return lft[4];
        if (z == 5) return t3(lft[3], lft[4], lft[4]);
        if (z % 2 == 0) return t2(lft[y+x/2+1], lft[y+x/2+2]);
        return t3(lft[y+x/2+1], lft[y+x/2+2], lft[y+x/2+3]);
      end
    endcase
  endfunction

  function automatic string tagOf(int i, int md);
    case (i)
      1:          return "R9";
      4, 15:      return "R10";
      6, 9:       return "R11";
      11, 12, 13: return "R8";
      default: begin
        if (md <= 1) return "R4";
        if (md == 2) return "R5";
        if (md <= 4) return "R6";
        return "R7";
      end
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic runBlock(int md, logic [3:0] mask, int bx, int by, string tag, bit injectStart);
    bit aL, aT, aTR, aTL;
    int exp [16];
    aL  = mask[0] && bx > 0;
    aT  = mask[1] && by > 0;
    aTR = mask[2] && by > 0 && bx < 3;
    aTL = mask[3] && bx > 0 && by > 0;
    for (int p = 0; p < 16; p++) exp[p] = refPix(md, aL, aT, aTR, aTL, bx, by, p);
    @(negedge clk);
    start = 1'b1;
    mode  = 4'(md);
    availLeft = aL; availTop = aT; availTopRight = aTR; availTopLeft = aTL;
    blkX  = 2'(bx);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2", int'(busy), 1);
    chk("R2", int'(predValid), 0);
    for (int p = 0; p < 16; p++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2", int'(predValid), 1);
      chk("R2", int'(predIdx), p);
      chk(tag, int'(predPix), exp[p]);
      if (injectStart && p == 5) begin
        start = 1'b1;
        mode  = 4'd1;
      end else begin
        start = 1'b0;
        mode  = 4'(md);
      end
    end
    chk("R2", int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2", int'(predValid), 0);
  endtask

  task automatic writeBack(int bx, int by);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      reconValid = 1'b1;
      reconIdx   = 4'(p);
      reconPix   = 8'(pic(bx*4 + p%4, by*4 + p/4));
    end
    @(negedge clk);
    reconValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(predValid), 0);
    chk("R1", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'(predValid), 0);
    chk("R1", int'(busy), 0);

    // Table walk over a 4x4-block picture; write-back after each block.
    for (int i = 0; i < 16; i++) begin
      runBlock(int'(VEC[i][7:4]), VEC[i][3:0], i % 4, i / 4, tagOf(i, int'(VEC[i][7:4])), 1'b0);
      writeBack(i % 4, i / 4);
    end

    // R3: start pulse with another mode in mid-burst; vertical prediction from row-3 bottoms.
    runBlock(0, 4'b0010, 1, 4, "R3", 1'b1);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      chk("R3", int'(predValid), 0);
      chk("R3", int'(busy), 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule